// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Front End

This block sits beside a small 8-bit processor core and decides which interrupt the core takes next. It has five request sources. One is a non-maskable trap. Three are maskable restart inputs, named by level 7.5, 6.5 and 5.5. The last is a general request line. The core gives the block mask writes, enable and disable strobes, and a strobe that marks an instruction boundary. At each boundary the block picks the winning request, if there is one. It then gives the core a one-cycle acknowledge, a stack push request and the fixed 16-bit vector address of the winning source.

The block also serves the core's software restart instruction. When that instruction runs with number n, the block gives a push request and the vector 8*n, but no acknowledge. A status word gives the core a view of the block:

- the serial input bit, captured in a register;
- the serial output bit, which the core sets through a mask write;
- the general and trap request levels;
- the global enable;
- the three restart masks.

Top module: `intr_front`

## Requirements
- R1: After reset the three restart masks are all 1 and the global enable is 0. The serial output, acknowledge, push request and vector are 0. With all inputs low the status word reads 0x07.
- R2: The status word bit map is: bit 7 serial input (registered), bit 6 serial output, bit 5 general request level, bit 4 trap level, bit 3 global enable, and bits 2..0 the masks for 7.5, 6.5 and 5.5.
- R3: A mask write loads bits 2..0 into the 7.5/6.5/5.5 masks only when bit 3 of the written byte is 1. Otherwise the masks keep their value. Bit 5 of the written byte has no effect on anything.
- R4: A mask write with bit 6 set copies bit 7 into the serial output. The serial input shows in status bit 7 one clock after it is applied.
- R5: The enable strobe sets the global enable and the disable strobe clears it; when both come in the same cycle, disable wins. Accepting any interrupt clears the global enable, and this overrides an enable strobe in the same cycle.
- R6: At an instruction boundary the winner is chosen in this order, highest first: trap, 7.5, 6.5, 5.5, general. A masked restart input never wins. No maskable source wins while the global enable is 0.
- R7: The trap wins at any boundary, whatever the enable and masks are. Taking a trap leaves the masks unchanged.
- R8: A rising edge on the 7.5 input sets a pending flag. The flag holds until the 7.5 interrupt is taken, or until a mask write with bit 4 set clears it. A new edge in the same cycle as a clear wins. The 6.5, 5.5 and general inputs act on their present level.
- R9: The vectors are 0x0024 for trap, 0x003C for 7.5, 0x0034 for 6.5, 0x002C for 5.5 and 0x0038 for general. The vector output holds its last value until the next vector event.
- R10: An accepted interrupt gives an acknowledge and a push request, each high for exactly the one clock after the boundary strobe. No acknowledge occurs without a boundary strobe.
- R11: A software restart strobe with number n gives a push request and the vector 8*n one clock later. It gives no acknowledge and does not change the enable. An interrupt accepted in the same cycle takes precedence and the restart strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_i | input | 1 | Non-maskable trap request (level) |
| r75_i | input | 1 | Restart 7.5 request (rising edge) |
| r65_i | input | 1 | Restart 6.5 request (level) |
| r55_i | input | 1 | Restart 5.5 request (level) |
| gen_i | input | 1 | General interrupt request (level) |
| boundary_i | input | 1 | Core is at an instruction boundary |
| ei_i | input | 1 | Enable-interrupts strobe |
| di_i | input | 1 | Disable-interrupts strobe |
| mwr_i | input | 1 | Mask write strobe |
| mwr_data_i | input | 8 | Mask write byte |
| swi_i | input | 1 | Software restart strobe |
| swi_num_i | input | 3 | Software restart number n |
| sin_i | input | 1 | Serial input data bit |
| status_o | output | 8 | Status word |
| sout_o | output | 1 | Serial output data bit |
| ack_o | output | 1 | Interrupt acknowledge pulse |
| push_o | output | 1 | Stack push request pulse |
| vec_o | output | 16 | Vector address |

## Verification
The bench builds the block with its default parameters: a 16-bit address, a 3-bit restart number and the fixed vector set. With the 3-bit restart number, all eight software restart vectors from 0x0000 to 0x0038 can be reached. The 16-bit vectors let the bench compare against the exact interrupt addresses. Directed sequences cover the priority order and the gating of the mask write. They also cover pending flags that are cleared in the same cycle as a new edge. Random stimulus then mixes every strobe against a bench model.

// File: rtl/intr_pkg.sv
package intr_pkg;
    // Grant vector layout for a design with NREQ maskable restart inputs:
    // [NREQ+1] trap, [NREQ:1] restart inputs (highest level at the top), [0] general
    localparam int unsigned NREQ_DEF = 3;

    function automatic int unsigned grant_width(int unsigned nreq);
        return nreq + 2;
    endfunction
endpackage

// File: rtl/intr_edge_latch.sv
module intr_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic clr_i,
    output logic pend_o
);
    typedef struct packed {
        logic prev;
        logic pend;
    } st_t;

    st_t st_d, st_q;
    logic rise;

    always_comb begin
        st_d      = st_q;
        rise      = lvl_i & ~st_q.prev;
        st_d.prev = lvl_i;
        if (clr_i) st_d.pend = 1'b0;
        if (rise)  st_d.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    AST_EDGE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_i && !st_q.prev) |=> pend_o); // R8
    AST_PEND_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_o && !(lvl_i && !st_q.prev)) |=> !pend_o); // R8
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter #(
    parameter int unsigned NREQ = intr_pkg::NREQ_DEF,
    localparam int unsigned GW  = intr_pkg::grant_width(NREQ)
) (
    input  logic            trap_i,
    input  logic            ie_i,
    input  logic [NREQ-1:0] req_i,
    input  logic            gen_i,
    output logic [GW-1:0]   grant_o
);
    logic [GW-1:0] cand;
    logic          taken;

    always_comb begin
        cand           = '0;
        cand[GW-1]     = trap_i;
        cand[NREQ:1]   = req_i & {NREQ{ie_i}};
        cand[0]        = gen_i & ie_i;
        grant_o        = '0;
        taken          = 1'b0;
        for (int i = GW - 1; i >= 0; i--) begin
            if (cand[i] && !taken) begin
                grant_o[i] = 1'b1;
                taken      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/intr_front.sv
module intr_front #(
    parameter int unsigned  ADDR_W   = 16,
    parameter int unsigned  RNUM_W   = 3,
    parameter logic [15:0]  VEC_TRAP = 16'h0024,
    parameter logic [15:0]  VEC_R75  = 16'h003C,
    parameter logic [15:0]  VEC_R65  = 16'h0034,
    parameter logic [15:0]  VEC_R55  = 16'h002C,
    parameter logic [15:0]  VEC_GEN  = 16'h0038
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_i,
    input  logic              r75_i,
    input  logic              r65_i,
    input  logic              r55_i,
    input  logic              gen_i,
    input  logic              boundary_i,
    input  logic              ei_i,
    input  logic              di_i,
    input  logic              mwr_i,
    input  logic [7:0]        mwr_data_i,
    input  logic              swi_i,
    input  logic [RNUM_W-1:0] swi_num_i,
    input  logic              sin_i,
    output logic [7:0]        status_o,
    output logic              sout_o,
    output logic              ack_o,
    output logic              push_o,
    output logic [ADDR_W-1:0] vec_o
);
    localparam int unsigned NREQ   = 3;
    localparam int unsigned GW     = intr_pkg::grant_width(NREQ);
    localparam int unsigned SLOT_W = 3;   // restart n lands at n * 2**SLOT_W

    // mask write byte fields
    localparam int unsigned B_SOUT  = 7;
    localparam int unsigned B_SOEN  = 6;
    localparam int unsigned B_CLR75 = 4;
    localparam int unsigned B_MSEN  = 3;

    typedef struct packed {
        logic [NREQ-1:0]   mask;
        logic              ie;
        logic              sout;
        logic              sin;
        logic              ack;
        logic              push;
        logic [ADDR_W-1:0] vec;
    } st_t;

    st_t st_d, st_q;

    logic            p75;
    logic            clr75;
    logic [NREQ-1:0] lvl;
    logic [GW-1:0]   grant;
    logic            accept;

    assign lvl = {p75, r65_i, r55_i} & ~st_q.mask;

    intr_arbiter #(.NREQ(NREQ)) u_arb (
        .trap_i  (trap_i & boundary_i),
        .ie_i    (st_q.ie & boundary_i),
        .req_i   (lvl),
        .gen_i   (gen_i),
        .grant_o (grant)
    );

    assign accept = |grant;
    assign clr75  = (mwr_i & mwr_data_i[B_CLR75]) | grant[NREQ];

    intr_edge_latch u_l75 (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (r75_i),
        .clr_i  (clr75),
        .pend_o (p75)
    );

    always_comb begin
        st_d      = st_q;
        st_d.sin  = sin_i;
        st_d.ack  = accept;
        st_d.push = accept | swi_i;

        if (mwr_i && mwr_data_i[B_MSEN]) st_d.mask = mwr_data_i[NREQ-1:0];
        if (mwr_i && mwr_data_i[B_SOEN]) st_d.sout = mwr_data_i[B_SOUT];

        if (ei_i) st_d.ie = 1'b1;
        if (di_i) st_d.ie = 1'b0;
        if (accept) st_d.ie = 1'b0;

        if (grant[GW-1])      st_d.vec = ADDR_W'(VEC_TRAP);
        else if (grant[3])    st_d.vec = ADDR_W'(VEC_R75);
        else if (grant[2])    st_d.vec = ADDR_W'(VEC_R65);
        else if (grant[1])    st_d.vec = ADDR_W'(VEC_R55);
        else if (grant[0])    st_d.vec = ADDR_W'(VEC_GEN);
        else if (swi_i)       st_d.vec = ADDR_W'({swi_num_i, {SLOT_W{1'b0}}});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = {st_q.sin, st_q.sout, gen_i, trap_i, st_q.ie, st_q.mask};
    assign sout_o   = st_q.sout;
    assign ack_o    = st_q.ack;
    assign push_o   = st_q.push;
    assign vec_o    = st_q.vec;

    AST_ACK_WITH_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> push_o); // R10
    AST_ACK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(boundary_i)); // R10
    AST_ACK_DROPS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> !status_o[3]); // R5
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mwr_i |=> $stable(status_o[2:0])); // R3
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R6
    AST_TRAP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_i && boundary_i) |=> (ack_o && vec_o == ADDR_W'(VEC_TRAP))); // R7
endmodule

// File: tb/test_intr_front.sv
module test_intr_front;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trap = 0, r75 = 0, r65 = 0, r55 = 0, gen = 0, bnd = 0;
    logic ei = 0, di = 0, mwr = 0, swi = 0, sin = 0;
    logic [7:0]  mdat = '0;
    logic [2:0]  snum = '0;
    logic [7:0]  status;
    logic        sout, ack, push;
    logic [15:0] vec;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #10 clk = ~clk;   // 50 MHz

    intr_front i_intr_front (
        .clk(clk), .rst_n(rst_n), .trap_i(trap), .r75_i(r75), .r65_i(r65),
        .r55_i(r55), .gen_i(gen), .boundary_i(bnd), .ei_i(ei), .di_i(di),
        .mwr_i(mwr), .mwr_data_i(mdat), .swi_i(swi), .swi_num_i(snum),
        .sin_i(sin), .status_o(status), .sout_o(sout), .ack_o(ack),
        .push_o(push), .vec_o(vec)
    );

    // bench model, written from the requirements
    logic [2:0]  m_mask = 3'b111;
    logic        m_ie = 0, m_sout = 0, m_sin = 0, m_p75 = 0, m_prev = 0;
    logic        m_ack = 0, m_push = 0;
    logic [15:0] m_vec = '0;

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] pick(logic [2:0] mask, logic ie, logic p75,
                                         logic t, logic a, logic b, logic g, logic bd);
        if (!bd)              return 16'hFFFF;      // no acceptance
        if (t)                return 16'h0024;       // R7
        if (!ie)              return 16'hFFFF;
        if (p75 && !mask[2])  return 16'h003C;       // R6 order
        if (a && !mask[1])    return 16'h0034;
        if (b && !mask[0])    return 16'h002C;
        if (g)                return 16'h0038;
        return 16'hFFFF;
    endfunction

    task automatic step();
        logic [15:0] w;
        w = pick(m_mask, m_ie, m_p75, trap, r65, r55, gen, bnd);
        @(posedge clk);
        if (mwr && mdat[3]) m_mask = mdat[2:0];
        if (mwr && mdat[6]) m_sout = mdat[7];
        if (ei) m_ie = 1;
        if (di) m_ie = 0;
        if (w != 16'hFFFF) m_ie = 0;
        if ((mwr && mdat[4]) || w == 16'h003C) m_p75 = 0;
        if (r75 && !m_prev) m_p75 = 1;
        m_prev = r75;
        m_sin  = sin;
        m_ack  = (w != 16'hFFFF);
        m_push = m_ack || swi;
        if (m_ack)    m_vec = w;
        else if (swi) m_vec = {10'd0, snum, 3'd0};
        @(negedge clk);
        check("R10 ack", {15'd0, ack}, {15'd0, m_ack});
        check("R10 push", {15'd0, push}, {15'd0, m_push});
        check("R9 vec", vec, m_vec);
        check("R4 sout", {15'd0, sout}, {15'd0, m_sout});
        check("R2 status", {8'd0, status},
              {8'd0, m_sin, m_sout, gen, trap, m_ie, m_mask});
    endtask

    task automatic idle();
        trap = 0; r65 = 0; r55 = 0; gen = 0; bnd = 0;
        ei = 0; di = 0; mwr = 0; swi = 0; mdat = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 status", {8'd0, status}, 16'h0007);
        check("R1 ack/push/sout", {13'd0, ack, push, sout}, 16'h0000);
        check("R1 vec", vec, 16'h0000);

        // R3: gated mask write
        mwr = 1; mdat = 8'h0D; step(); idle();
        check("R3 mask load", {13'd0, status[2:0]}, 16'h0005);
        mwr = 1; mdat = 8'h02; step(); idle();
        check("R3 mask held", {13'd0, status[2:0]}, 16'h0005);
        mwr = 1; mdat = 8'h20; step(); idle();   // R3: bit 5 only, no effect
        check("R3 bit5 ignored", {8'd0, status}, 16'h0005);

        // R4: serial out and in
        mwr = 1; mdat = 8'hC0; sin = 1; step(); idle();
        check("R4 sout set", {15'd0, sout}, 16'h0001);
        check("R4 sin seen", {15'd0, status[7]}, 16'h0001);
        sin = 0;

        // R5 / R6: enable, then priority among 6.5, 5.5, general
        mwr = 1; mdat = 8'h08; ei = 1; step(); idle();
        check("R5 ie set", {15'd0, status[3]}, 16'h0001);
        r65 = 1; r55 = 1; gen = 1; bnd = 1; step(); idle();
        check("R6 6.5 wins", vec, 16'h0034);
        check("R5 ie cleared", {15'd0, status[3]}, 16'h0000);
        check("R10 pulse high", {15'd0, ack}, 16'h0001);
        step();
        check("R10 pulse one cycle", {15'd0, ack}, 16'h0000);

        // R7: trap with enable off and masks set
        mwr = 1; mdat = 8'h0F; step(); idle();
        trap = 1; bnd = 1; step(); idle();
        check("R7 trap vec", vec, 16'h0024);
        check("R7 masks kept", {13'd0, status[2:0]}, 16'h0007);

        // R8: 7.5 edge latched, then serviced once
        mwr = 1; mdat = 8'h08; ei = 1; r75 = 1; step(); idle();
        r75 = 0; step(); step();
        bnd = 1; step(); idle();
        check("R8 7.5 taken", vec, 16'h003C);
        ei = 1; step(); idle();
        bnd = 1; step(); idle();
        check("R8 pending cleared", {15'd0, ack}, 16'h0000);
        // R8: clear via mask write bit 4
        r75 = 1; step(); r75 = 0;
        mwr = 1; mdat = 8'h10; step(); idle();
        bnd = 1; step(); idle();
        check("R8 clear by write", {15'd0, ack}, 16'h0000);

        // R11: software restart
        swi = 1; snum = 3'd5; step(); idle();
        check("R11 vec", vec, 16'h0028);
        check("R11 push no ack", {14'd0, push, ack}, 16'h0002);

        // random phase
        void'($urandom(32'h1234_5678));
        for (int k = 0; k < 4000; k++) begin
            trap = ($urandom % 24) == 0;
            r75  = $urandom % 2;
            r65  = ($urandom % 4) == 0;
            r55  = ($urandom % 4) == 0;
            gen  = ($urandom % 3) == 0;
            bnd  = ($urandom % 4) == 0;
            ei   = ($urandom % 6) == 0;
            di   = ($urandom % 16) == 0;
            mwr  = ($urandom % 8) == 0;
            mdat = 8'($urandom);
            swi  = ($urandom % 8) == 0;
            snum = 3'($urandom);
            sin  = $urandom % 2;
            step();
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog act=running exp=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule